// File: doc/BRIEF.md
# Wide Add-Subtract Datapath with Flag Groups

This block is the arithmetic slice of a wide-word coprocessor. It takes two 256-bit operands from the register file and an optional small immediate. It computes one of ten add, subtract, compare or modular operations. The result word and a set of condition flags are registered on the clock edge where `valid_i` is high. Before the arithmetic, the second operand can be moved left or right by a whole number of bytes. This lets multi-word arithmetic line up partial words without a separate shift step.

Two independent flag groups are kept, and each operation reads and writes the group that `flag_sel_i` names. A chain of add-with-carry or subtract-with-borrow steps can therefore run in one group while the other group holds an unrelated comparison. Subtraction keeps a borrow (the inverse of the carry) in the C flag. The modular add and subtract use a 256-bit modulus register, which is loaded through its own write port. They apply exactly one conditional correction against that modulus.

Top module: `bignum_addsub`

## Requirements
- R1: While `rst_n` is low, `result_o`, `flags_o`, `result_we_o` and the modulus register are all zero.
- R2: With `valid_i` high, op 0 (add) stores A+B mod 2^256 and op 2 (add-immediate) stores A plus the zero-extended `imm_i`. The store lands in `result_o` on that clock edge, and `result_we_o` is high for the following cycle after every result store.
- R3: Flag group g sits at `flags_o[4g+3:4g]` with bit 0 = C, bit 1 = L (result bit 0), bit 2 = M (result bit 255) and bit 3 = Z (result is zero). After an add, C is the carry out of bit 255.
- R4: For ops 0, 1, 3, 4, 6 and 7, B is first shifted by `shift_bytes_i` whole bytes, to the right when `shift_right_i` is 1 and to the left when it is 0. Vacated bytes are filled with zero. Immediate and modular ops use B or the immediate unshifted.
- R5: Op 1 (add-with-carry) adds the C flag of the selected group as its carry-in.
- R6: Op 3 (subtract) and op 5 (subtract-immediate) store A-B mod 2^256 and set C to 1 exactly when a borrow occurs. Op 4 (subtract-with-borrow) also subtracts the selected group's C.
- R7: Op 6 (compare) and op 7 (compare-with-borrow) set flags as op 3 and op 4 would. They leave `result_o` unchanged and do not raise `result_we_o`.
- R8: Op 8 (modular add) forms the 257-bit sum A+B and stores it minus the modulus when the sum is not below the modulus, otherwise the sum itself.
- R9: Op 9 (modular subtract) stores A-B when A >= B and A-B+modulus (mod 2^256) when A < B.
- R10: Modular ops leave all flags unchanged. A modulus written with `mod_we_i` is used only from the next cycle on, so an op in the same cycle still sees the old value.
- R11: An op updates only the flag group that `flag_sel_i` selects; the other group keeps its value.
- R12: When `valid_i` is low, or when the op code is 10 to 15, `result_o` and `flags_o` hold and `result_we_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Executes the op on this edge |
| op_i | input | 4 | Operation code |
| a_i | input | 256 | Operand A |
| b_i | input | 256 | Operand B |
| imm_i | input | 10 | Immediate for the immediate forms |
| shift_right_i | input | 1 | Byte shift direction for B, 1 = right |
| shift_bytes_i | input | 5 | Byte shift count for B |
| flag_sel_i | input | 1 | Selects the flag group read and written |
| mod_we_i | input | 1 | Loads the modulus register |
| mod_wdata_i | input | 256 | New modulus value |
| result_o | output | 256 | Registered result word |
| result_we_o | output | 1 | High for one cycle after a result store |
| flags_o | output | 8 | Both flag groups, four bits each |

## Verification
The bench builds the block with its defaults: 256-bit words, two flag groups, a 10-bit immediate and a 5-bit byte count. At this width, all-ones operands reach a real carry out of bit 255. A modulus just below 2^256 makes the modular sum exceed 256 bits before the correction. With two groups, a borrow chain can run in group 1 while the bench checks that group 0 holds. Byte counts of 0, 1 and 31 cover both ends of the shifter in both directions.

// File: rtl/bn_pkg.sv
package bn_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_ADDI = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBB = 4'd4,
    OP_SUBI = 4'd5,
    OP_CMP  = 4'd6,
    OP_CMPB = 4'd7,
    OP_ADDM = 4'd8,
    OP_SUBM = 4'd9
  } bn_op_e;

  // bit 0 = c, bit 3 = z
  typedef struct packed {
    logic z;
    logic m;
    logic l;
    logic c;
  } bn_flags_t;

  function automatic logic op_writes(bn_op_e o);
    return o inside {OP_ADD, OP_ADDC, OP_ADDI, OP_SUB, OP_SUBB, OP_SUBI,
                     OP_ADDM, OP_SUBM};
  endfunction

  function automatic logic op_sets_flags(bn_op_e o);
    return o inside {OP_ADD, OP_ADDC, OP_ADDI, OP_SUB, OP_SUBB, OP_SUBI,
                     OP_CMP, OP_CMPB};
  endfunction

  function automatic logic op_negates_b(bn_op_e o);
    return o inside {OP_SUB, OP_SUBB, OP_SUBI, OP_CMP, OP_CMPB, OP_SUBM};
  endfunction

  function automatic logic op_is_mod(bn_op_e o);
    return o inside {OP_ADDM, OP_SUBM};
  endfunction

  function automatic logic op_is_imm(bn_op_e o);
    return o inside {OP_ADDI, OP_SUBI};
  endfunction

  // carry-in for the single wide adder; c is the selected group's C flag
  function automatic logic op_carry_in(bn_op_e o, logic c);
    case (o)
      OP_ADDC:                             return c;
      OP_SUB, OP_SUBI, OP_CMP, OP_SUBM:    return 1'b1;
      OP_SUBB, OP_CMPB:                    return ~c;
      default:                             return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bn_byte_shift.sv
module bn_byte_shift #(
  parameter int W = 256,
  localparam int NB = W / 8,
  localparam int SBW = $clog2(NB)
) (
  input  logic [W-1:0]   data_i,
  input  logic           right_i,
  input  logic [SBW-1:0] nbytes_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (nbytes_i == SBW'(k))
        data_o = right_i ? (data_i >> (8 * k)) : (data_i << (8 * k));
    end
  end
endmodule

// File: rtl/bn_adder.sv
module bn_adder #(
  parameter int W = 256
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  always_comb begin
    {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end
endmodule

// File: rtl/bn_mod_fix.sv
module bn_mod_fix #(
  parameter int W = 256
) (
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  input  logic         is_sub_i,
  input  logic [W-1:0] modulus_i,
  output logic [W-1:0] res_o,
  output logic         fix_o
);
  logic not_below;
  assign not_below = {cout_i, sum_i} >= {1'b0, modulus_i};

  always_comb begin
    if (is_sub_i) begin
      fix_o = ~cout_i;  // borrow out of A + ~B + 1
      res_o = fix_o ? (sum_i + modulus_i) : sum_i;
    end else begin
      fix_o = not_below;
      res_o = fix_o ? (sum_i - modulus_i) : sum_i;
    end
  end
endmodule

// File: rtl/bignum_addsub.sv
module bignum_addsub
  import bn_pkg::*;
#(
  parameter int W = 256,
  parameter int NGROUPS = 2,
  parameter int IMMW = 10,
  localparam int SBW = $clog2(W / 8),
  localparam int GW = $clog2(NGROUPS),
  localparam int FW = 4 * NGROUPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [3:0]      op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            shift_right_i,
  input  logic [SBW-1:0]  shift_bytes_i,
  input  logic [GW-1:0]   flag_sel_i,
  input  logic            mod_we_i,
  input  logic [W-1:0]    mod_wdata_i,
  output logic [W-1:0]    result_o,
  output logic            result_we_o,
  output logic [FW-1:0]   flags_o
);
  bn_op_e    op;
  logic [W-1:0] b_shifted, b_sel, b_eff, sum, mod_res, res_next;
  logic      cout, cin, fix_applied, negate_b, do_write, do_flags;
  bn_flags_t cur_flags, new_flags;
  bn_flags_t flags_q [NGROUPS];
  logic [W-1:0] result_q, mod_q;
  logic      we_q;

  assign op        = bn_op_e'(op_i);
  assign cur_flags = flags_q[flag_sel_i];
  assign negate_b  = op_negates_b(op);
  assign cin       = op_carry_in(op, cur_flags.c);
  assign do_write  = valid_i && op_writes(op);
  assign do_flags  = valid_i && op_sets_flags(op);

  bn_byte_shift #(.W(W)) u_shift (
    .data_i(b_i), .right_i(shift_right_i), .nbytes_i(shift_bytes_i),
    .data_o(b_shifted)
  );

  always_comb begin
    if (op_is_imm(op))      b_sel = W'(imm_i);
    else if (op_is_mod(op)) b_sel = b_i;
    else                    b_sel = b_shifted;
  end
  assign b_eff = negate_b ? ~b_sel : b_sel;

  bn_adder #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  bn_mod_fix #(.W(W)) u_fix (
    .sum_i(sum), .cout_i(cout), .is_sub_i(negate_b), .modulus_i(mod_q),
    .res_o(mod_res), .fix_o(fix_applied)
  );

  assign res_next    = op_is_mod(op) ? mod_res : sum;
  assign new_flags.c = negate_b ? ~cout : cout;
  assign new_flags.l = sum[0];
  assign new_flags.m = sum[W-1];
  assign new_flags.z = ~|sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      we_q     <= 1'b0;
      mod_q    <= '0;
    end else begin
      we_q <= do_write;
      if (do_write) result_q <= res_next;
      if (mod_we_i) mod_q <= mod_wdata_i;
    end
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flags_q[g] <= '0;
      else if (do_flags && flag_sel_i == GW'(g)) flags_q[g] <= new_flags;
    end
    assign flags_o[4*g +: 4] = flags_q[g];

    // R11
    other_grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && flag_sel_i != GW'(g)) |=> $stable(flags_q[g]));
  end

  assign result_o    = result_q;
  assign result_we_o = we_q;

  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op == OP_CMP || op == OP_CMPB)) |=> ($stable(result_o) && !result_we_o));

  // R10
  mod_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_is_mod(op)) |=> $stable(flags_o));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || op_i > 4'd9) |=> ($stable(result_o) && $stable(flags_o) && !result_we_o));

  // R3
  z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && do_flags) |=> (flags_q[$past(flag_sel_i)].z == (result_o == '0)));

  // R8
  mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_ADDM && a_i < mod_q && b_i < mod_q) |=> (result_o < $past(mod_q)));

  // R9
  mod_sub_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_SUBM && a_i >= b_i) |=> (!$past(fix_applied) && result_o == $past(a_i - b_i)));
endmodule

// File: tb/bignum_addsub_bench.sv
module bignum_addsub_bench;
  localparam int W = 256;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid_i = 1'b0;
  logic [3:0]     op_i = '0;
  logic [W-1:0]   a_i = '0, b_i = '0, mod_wdata_i = '0;
  logic [9:0]     imm_i = '0;
  logic           shift_right_i = 1'b0;
  logic [4:0]     shift_bytes_i = '0;
  logic [0:0]     flag_sel_i = '0;
  logic           mod_we_i = 1'b0;
  logic [W-1:0]   result_o;
  logic           result_we_o;
  logic [7:0]     flags_o;

  int n_checks = 0;
  int n_fail = 0;

  logic [W-1:0] exp_res = '0;
  logic [W-1:0] exp_mod = '0;
  logic [3:0]   exp_flags [2] = '{4'h0, 4'h0};

  localparam logic [W-1:0] ONES = {W{1'b1}};

  always #4 clk = ~clk;

  bignum_addsub u_bignum_addsub (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
    .b_i(b_i), .imm_i(imm_i), .shift_right_i(shift_right_i),
    .shift_bytes_i(shift_bytes_i), .flag_sel_i(flag_sel_i),
    .mod_we_i(mod_we_i), .mod_wdata_i(mod_wdata_i), .result_o(result_o),
    .result_we_o(result_we_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic exp_we);
    check({tag, " result"}, result_o, exp_res);
    check({tag, " flags"}, W'(flags_o), W'({exp_flags[1], exp_flags[0]}));
    check({tag, " we"}, W'(result_we_o), W'(exp_we));
  endtask

  // Drive one op at a negedge, let one edge pass, check at the next negedge.
  task automatic run_op(input string tag, input int op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [9:0] imm,
                        input logic sr, input logic [4:0] nb, input int grp,
                        input logic ldm, input logic [W-1:0] newm);
    logic [256:0] s;
    logic [W-1:0] bb;
    logic c;
    logic wr, fl;
    c  = exp_flags[grp][0];
    bb = sr ? (b >> (8 * nb)) : (b << (8 * nb));
    wr = 1'b1;
    fl = 1'b1;
    s  = '0;
    case (op)
      0: s = {1'b0, a} + {1'b0, bb};
      1: s = {1'b0, a} + {1'b0, bb} + 257'(c);
      2: s = {1'b0, a} + 257'(imm);
      3: s = {1'b0, a} - {1'b0, bb};
      4: s = {1'b0, a} - {1'b0, bb} - 257'(c);
      5: s = {1'b0, a} - 257'(imm);
      6: begin s = {1'b0, a} - {1'b0, bb}; wr = 1'b0; end
      7: begin s = {1'b0, a} - {1'b0, bb} - 257'(c); wr = 1'b0; end
      8: begin
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, exp_mod}) s = s - {1'b0, exp_mod};
        fl = 1'b0;
      end
      9: begin
        s = {1'b0, a} - {1'b0, b};
        if (s[256]) s = s + {1'b0, exp_mod};
        fl = 1'b0;
      end
      default: begin wr = 1'b0; fl = 1'b0; end
    endcase
    valid_i = 1'b1; op_i = 4'(op); a_i = a; b_i = b; imm_i = imm;
    shift_right_i = sr; shift_bytes_i = nb; flag_sel_i = 1'(grp);
    mod_we_i = ldm; mod_wdata_i = newm;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0; mod_we_i = 1'b0;
    if (wr) exp_res = s[W-1:0];
    if (fl) exp_flags[grp] = {s[W-1:0] == '0, s[W-1], s[0], s[256]};
    if (ldm) exp_mod = newm;
    check_all(tag, wr);
  endtask

  task automatic op(input string tag, input int code, input logic [W-1:0] a,
                    input logic [W-1:0] b, input int grp);
    run_op(tag, code, a, b, '0, 1'b0, '0, grp, 1'b0, '0);
  endtask

  task automatic load_mod(input logic [W-1:0] m);
    mod_we_i = 1'b1; mod_wdata_i = m;
    @(posedge clk);
    @(negedge clk);
    mod_we_i = 1'b0;
    exp_mod = m;
  endtask

  task automatic t_reset;
    check("R1 result", result_o, '0);
    check("R1 flags", W'(flags_o), '0);
    check("R1 we", W'(result_we_o), '0);
  endtask

  task automatic t_add;
    op("R2 add small", 0, 256'd1234, 256'd4321, 0);
    op("R3 add overflow to zero", 0, ONES, 256'd1, 0);
    op("R3 add top bit", 0, {1'b1, 255'd0}, 256'd3, 0);
    run_op("R2 addi", 2, 256'd100, ONES, 10'h3ff, 1'b0, '0, 0, 1'b0, '0);
  endtask

  task automatic t_shift;
    run_op("R4 left 1 byte", 0, '0, 256'h00ab_cdef, '0, 1'b0, 5'd1, 0, 1'b0, '0);
    run_op("R4 right 31 bytes", 0, 256'd5, {8'hc3, 248'd0}, '0, 1'b1, 5'd31, 0, 1'b0, '0);
    run_op("R4 left 31 drops", 0, '0, {8'hff, 248'h77}, '0, 1'b0, 5'd31, 0, 1'b0, '0);
    run_op("R4 subi ignores shift", 5, 256'd50, ONES, 10'd7, 1'b1, 5'd3, 0, 1'b0, '0);
  endtask

  task automatic t_carry;
    op("R5 set carry", 0, ONES, ONES, 0);
    op("R5 addc uses C", 1, 256'd0, 256'd0, 0);
    op("R5 addc C clear", 1, 256'd9, 256'd1, 0);
  endtask

  task automatic t_sub;
    op("R6 sub borrow", 3, 256'd5, 256'd7, 1);
    op("R6 subb chain", 4, 256'd7, 256'd7, 1);
    op("R6 sub no borrow", 3, 256'd9, 256'd2, 1);
    op("R6 subb no borrow in", 4, 256'd9, 256'd2, 1);
    run_op("R6 subi", 5, 256'd3, '0, 10'd4, 1'b0, '0, 1, 1'b0, '0);
  endtask

  task automatic t_cmp;
    op("R7 cmp less", 6, 256'd1, 256'd2, 0);
    op("R7 cmp equal", 6, 256'd42, 256'd42, 0);
    op("R7 cmpb", 7, 256'd42, 256'd41, 0);
  endtask

  task automatic t_mod;
    load_mod(256'd1000);
    op("R8 below modulus", 8, 256'd300, 256'd400, 0);
    op("R8 equal modulus", 8, 256'd600, 256'd400, 0);
    op("R8 above modulus", 8, 256'd999, 256'd999, 0);
    op("R9 a below b", 9, 256'd10, 256'd20, 0);
    op("R9 a above b", 9, 256'd20, 256'd10, 0);
    load_mod(ONES - 256'd4);
    op("R8 wide sum", 8, ONES - 256'd5, ONES - 256'd5, 1);
    op("R10 flags hold on mod", 9, 256'd0, 256'd1, 1);
  endtask

  task automatic t_mod_timing;
    load_mod(256'd100);
    run_op("R10 same-cycle load uses old", 8, 256'd60, 256'd60, '0, 1'b0, '0, 0,
           1'b1, 256'd500);
    op("R10 new modulus next cycle", 8, 256'd60, 256'd60, 0);
  endtask

  task automatic t_groups;
    op("R11 grp1 borrow", 3, 256'd0, 256'd1, 1);
    op("R11 grp0 zero", 3, 256'd8, 256'd8, 0);
    op("R11 grp1 addc sees own C", 1, 256'd0, 256'd0, 1);
  endtask

  task automatic t_idle;
    valid_i = 1'b0; op_i = 4'd0; a_i = ONES; b_i = ONES;
    @(posedge clk);
    @(negedge clk);
    check_all("R12 valid low", 1'b0);
    op("R12 code 12", 12, ONES, 256'd3, 0);
    op("R12 code 15", 15, 256'd1, 256'd3, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_add;
    t_shift;
    t_carry;
    t_sub;
    t_cmp;
    t_mod;
    t_mod_timing;
    t_groups;
    t_idle;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule